// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block runs ahead of the execution unit and reads program bytes into a small byte queue. The instruction decoder takes bytes from the head of the queue over a valid/accept handshake. The block keeps its own fetch counter, which advances by one for every byte written into the queue. The head-of-queue address is the fetch counter minus the number of queued bytes, and it is presented next to each byte.

The block has one memory port. That port is shared between queue fills and byte reads and writes requested by the execution unit. On the memory port a request is raised and then held unchanged until the memory acknowledges it. Read data comes back in the acknowledging cycle. When both sides want the idle port, the queue fill goes first. A change of program flow (jump, call, return or interrupt) arrives as a one-cycle redirect carrying the new target. The redirect empties the queue, reloads the fetch counter and holds off fetching, so that with a memory that acknowledges in the same cycle the first target byte reaches the decoder a fixed number of cycles after the redirect.

Top module: `pfq_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`dec_valid` low) and the first memory request is a fetch from address `RESET_ADDR` (default 0x2080).
- R2: Bytes reach the decoder in ascending address order. Each byte equals the memory contents at `dec_addr`, and after each accepted byte (with no redirect in that cycle) `dec_addr` advances by one.
- R3: The queue never holds more than `DEPTH` bytes. While it is full no fetch is presented. In the cycle after the decoder accepts a byte from a full queue, the next fetch is presented.
- R4: When the port is free and a fetch is wanted, the fetch is presented even if the execution unit is requesting. The data request is granted only once the queue is full.
- R5: A data transfer completes in the cycle where `du_done` is high. In that cycle the memory port carries `du_addr`, `du_we` and, for a write, `du_wdata`, and for a read `du_rdata` returns the memory byte.
- R6: Once `mem_req` is raised without `mem_ack`, the request stays raised with the same address, write flag and write data until acknowledged.
- R7: In the cycle after a redirect the queue is empty, and the next byte delivered is the one at the redirect target.
- R8: With a memory that acknowledges in the same cycle, no fetch is presented in the `REDIRECT_STATES-2` cycles after the redirect cycle. The target byte is valid to the decoder exactly `REDIRECT_STATES` (default 4) cycles after the redirect cycle.
- R9: A fetch still unacknowledged when a redirect arrives is completed on the port but its byte is discarded. The first byte delivered afterwards is the target byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | One-cycle program flow change |
| redir_target | input | AW | New fetch address for the redirect |
| dec_valid | output | 1 | Queue head holds a byte |
| dec_byte | output | 8 | Byte at the queue head |
| dec_addr | output | AW | Address of the byte at the queue head |
| dec_accept | input | 1 | Decoder takes the head byte |
| du_req | input | 1 | Execution unit data request, held until done |
| du_we | input | 1 | Data request is a write |
| du_addr | input | AW | Data request address |
| du_wdata | input | 8 | Data request write byte |
| du_done | output | 1 | Data request completes this cycle |
| du_rdata | output | 8 | Read byte for a completing data read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge, completes the request this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 4-byte queue and a 4-cycle redirect penalty. With the short queue, four same-cycle fetches fill it. That makes the full-queue stall, the resume after a single accept and the starving of a competing data request all visible within a few cycles. Stretches with a memory that never stalls expose the exact redirect timing. A forced stall across a redirect leaves a stale fetch on the port, and the bench checks that the stale byte never reaches the decoder.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_FETCH = 2'd1,
      OWN_DATA  = 2'd2
   } port_owner_t;
endpackage

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue
   import pfq_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [BYTE_W-1:0] push_byte,
   input  logic              pop,
   output logic [BYTE_W-1:0] head_byte,
   output logic [CW-1:0]     count
);
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;
   logic [BYTE_W-1:0] cell_rd [DEPTH];

   // one storage cell per entry, written only when the write pointer selects it
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (push && !flush && wr_ptr == PW'(i)) begin
            cell_q <= push_byte;
         end
      end
      assign cell_rd[i] = cell_q;
   end

   assign head_byte = cell_rd[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
   parameter int unsigned    AW              = 16,
   parameter int unsigned    DEPTH           = 4,
   parameter int unsigned    REDIRECT_STATES = 4,
   parameter logic [AW-1:0]  RESET_ADDR      = 'h2080,
   localparam int unsigned   CW              = $clog2(DEPTH + 1),
   localparam int unsigned   HW              = $clog2(REDIRECT_STATES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          redir_valid,
   input  logic [AW-1:0] redir_target,
   input  logic [CW-1:0] q_count,
   input  logic          fetch_busy,
   input  logic          fetch_ack,
   output logic          fetch_want,
   output logic [AW-1:0] fetch_pc,
   output logic          push
);
   logic [HW-1:0] hold_q;
   logic          stale_q;

   // a returning byte is kept only if no redirect has passed since it was requested
   assign push       = fetch_ack && !stale_q && !redir_valid;
   assign fetch_want = (hold_q == '0) && (q_count < CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_pc <= RESET_ADDR;
         hold_q   <= '0;
         stale_q  <= 1'b0;
      end else begin
         if (redir_valid)      fetch_pc <= redir_target;
         else if (push)        fetch_pc <= fetch_pc + AW'(1);

         if (redir_valid)      hold_q <= HW'(REDIRECT_STATES - 2);
         else if (hold_q != 0) hold_q <= hold_q - HW'(1);

         if (redir_valid && fetch_busy && !fetch_ack) stale_q <= 1'b1;
         else if (fetch_ack)                          stale_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pfq_port_arb.sv
module pfq_port_arb
   import pfq_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_want,
   input  logic [AW-1:0]     fetch_addr,
   input  logic              du_req,
   input  logic              du_we,
   input  logic [AW-1:0]     du_addr,
   input  logic [BYTE_W-1:0] du_wdata,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              du_done,
   output logic              fetch_busy,
   output logic              fetch_ack,
   output logic              port_locked
);
   port_owner_t   owner_q;
   port_owner_t   cur;
   logic [AW-1:0] lock_addr_q;

   // a presented but unacknowledged request keeps the port; otherwise fetch wins
   always_comb begin
      if (owner_q != OWN_NONE) cur = owner_q;
      else if (fetch_want)     cur = OWN_FETCH;
      else if (du_req)         cur = OWN_DATA;
      else                     cur = OWN_NONE;
   end

   assign port_locked = (owner_q != OWN_NONE);
   assign mem_req     = (cur != OWN_NONE);
   assign mem_we      = (cur == OWN_DATA) && du_we;
   assign mem_wdata   = (cur == OWN_DATA) ? du_wdata : '0;
   assign fetch_busy  = (cur == OWN_FETCH);
   assign fetch_ack   = fetch_busy && mem_ack;
   assign du_done     = (cur == OWN_DATA) && mem_ack;

   always_comb begin
      if (cur == OWN_DATA)         mem_addr = du_addr;
      else if (owner_q == OWN_FETCH) mem_addr = lock_addr_q;
      else                         mem_addr = fetch_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q     <= OWN_NONE;
         lock_addr_q <= '0;
      end else begin
         owner_q <= (mem_req && !mem_ack) ? cur : OWN_NONE;
         if (mem_req && !mem_ack) lock_addr_q <= mem_addr;
      end
   end
endmodule

// File: rtl/pfq_prefetch_queue.sv
module pfq_prefetch_queue
   import pfq_pkg::*;
#(
   parameter int unsigned   AW              = 16,
   parameter int unsigned   DEPTH           = 4,
   parameter int unsigned   REDIRECT_STATES = 4,
   parameter logic [AW-1:0] RESET_ADDR      = 'h2080,
   localparam int unsigned  CW              = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_valid,
   input  logic [AW-1:0]     redir_target,
   output logic              dec_valid,
   output logic [BYTE_W-1:0] dec_byte,
   output logic [AW-1:0]     dec_addr,
   input  logic              dec_accept,
   input  logic              du_req,
   input  logic              du_we,
   input  logic [AW-1:0]     du_addr,
   input  logic [BYTE_W-1:0] du_wdata,
   output logic              du_done,
   output logic [BYTE_W-1:0] du_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [BYTE_W-1:0] mem_rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (REDIRECT_STATES < 3) begin : g_bad_penalty
      $error("REDIRECT_STATES must be at least 3");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end

   logic [CW-1:0]     q_count;
   logic              fetch_want;
   logic [AW-1:0]     fetch_pc;
   logic              push;
   logic              pop;
   logic              fetch_busy;
   logic              fetch_ack;
   logic              port_locked;

   assign dec_valid = (q_count != '0);
   assign pop       = dec_valid && dec_accept && !redir_valid;
   assign dec_addr  = fetch_pc - AW'(q_count);
   assign du_rdata  = mem_rdata;

   pfq_byte_queue #(.DEPTH(DEPTH)) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (redir_valid),
      .push      (push),
      .push_byte (mem_rdata),
      .pop       (pop),
      .head_byte (dec_byte),
      .count     (q_count)
   );

   pfq_fetch_ctl #(
      .AW              (AW),
      .DEPTH           (DEPTH),
      .REDIRECT_STATES (REDIRECT_STATES),
      .RESET_ADDR      (RESET_ADDR)
   ) i_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .redir_valid  (redir_valid),
      .redir_target (redir_target),
      .q_count      (q_count),
      .fetch_busy   (fetch_busy),
      .fetch_ack    (fetch_ack),
      .fetch_want   (fetch_want),
      .fetch_pc     (fetch_pc),
      .push         (push)
   );

   pfq_port_arb #(.AW(AW)) i_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_want  (fetch_want),
      .fetch_addr  (fetch_pc),
      .du_req      (du_req),
      .du_we       (du_we),
      .du_addr     (du_addr),
      .du_wdata    (du_wdata),
      .mem_ack     (mem_ack),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .du_done     (du_done),
      .fetch_busy  (fetch_busy),
      .fetch_ack   (fetch_ack),
      .port_locked (port_locked)
   );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          redir_valid,
   input logic          dec_valid,
   input logic          dec_accept,
   input logic [AW-1:0] dec_addr,
   input logic          du_req,
   input logic          du_we,
   input logic [AW-1:0] du_addr,
   input logic          du_done,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [7:0]    mem_wdata,
   input logic [CW-1:0] q_count,
   input logic          fetch_want,
   input logic          port_locked
);
   assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_accept && !redir_valid) |=>
         (!dec_valid || dec_addr == $past(dec_addr) + AW'(1)));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   assert_full_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == CW'(DEPTH) && !port_locked) |-> (mem_req == du_req));

   assert_fetch_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_locked && fetch_want) |-> !du_done);

   assert_data_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      du_done |-> (mem_req && mem_ack && mem_addr == du_addr && mem_we == du_we));

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !dec_valid);

   assert_penalty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !fetch_want);
endmodule

bind pfq_prefetch_queue pfq_checker #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) i_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .redir_valid (redir_valid),
   .dec_valid   (dec_valid),
   .dec_accept  (dec_accept),
   .dec_addr    (dec_addr),
   .du_req      (du_req),
   .du_we       (du_we),
   .du_addr     (du_addr),
   .du_done     (du_done),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .q_count     (q_count),
   .fetch_want  (fetch_want),
   .port_locked (port_locked)
);

// File: tb/test_pfq_prefetch_queue.sv
`timescale 1ns/1ps
module test_pfq_prefetch_queue;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          redir_valid = 1'b0;
   logic [AW-1:0] redir_target = '0;
   logic          dec_valid;
   logic [7:0]    dec_byte;
   logic [AW-1:0] dec_addr;
   logic          dec_accept = 1'b0;
   logic          du_req = 1'b0;
   logic          du_we = 1'b0;
   logic [AW-1:0] du_addr = '0;
   logic [7:0]    du_wdata = '0;
   logic          du_done;
   logic [7:0]    du_rdata;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_ack;
   logic [7:0]    mem_rdata;
   logic          stall = 1'b0;

   int nchk = 0;
   int nfail = 0;
   int fetch_acks = 0;
   bit mon_en = 1'b0;
   bit prev_pend = 1'b0;
   logic [AW-1:0] prev_addr;
   logic          prev_we;
   logic [7:0]    prev_wdata;
   logic [AW-1:0] exp_head = 16'h2080;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
   endfunction

   assign mem_ack   = mem_req && !stall;
   assign mem_rdata = mem_byte(mem_addr);

   pfq_prefetch_queue i_pfq_prefetch_queue (
      .clk (clk), .rst_n (rst_n),
      .redir_valid (redir_valid), .redir_target (redir_target),
      .dec_valid (dec_valid), .dec_byte (dec_byte), .dec_addr (dec_addr),
      .dec_accept (dec_accept),
      .du_req (du_req), .du_we (du_we), .du_addr (du_addr), .du_wdata (du_wdata),
      .du_done (du_done), .du_rdata (du_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // checks that run every cycle once reset is released
   task automatic monitor();
      if (!mon_en) begin
         prev_pend = 1'b0;
         return;
      end
      if (prev_pend) begin  // R6
         check(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
               (!prev_we || mem_wdata == prev_wdata), "R6 held request",
               {15'd0, mem_req, mem_addr}, {16'd1, prev_addr});
      end
      prev_pend  = mem_req && !mem_ack;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      prev_wdata = mem_wdata;
      if (mem_req && mem_ack && !du_done) fetch_acks++;
      if (du_done) begin  // R5
         check(mem_addr == du_addr && mem_we == du_we, "R5 data port address",
               {15'd0, mem_we, mem_addr}, {15'd0, du_we, du_addr});
         if (du_we) check(mem_wdata == du_wdata, "R5 write byte", mem_wdata, du_wdata);
         else       check(du_rdata == mem_byte(du_addr), "R5 read byte",
                          du_rdata, mem_byte(du_addr));
      end
      if (dec_valid && dec_accept && !redir_valid) begin  // R2
         check(dec_addr == exp_head && dec_byte == mem_byte(exp_head), "R2 byte order",
               {dec_addr, dec_byte}, {exp_head, mem_byte(exp_head)});
         exp_head = exp_head + 16'd1;
      end
      if (redir_valid) exp_head = redir_target;
   endtask

   task automatic settle();
      #1;
      monitor();
   endtask

   task automatic next();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) next();
      rst_n  = 1'b1;
      mon_en = 1'b1;

      // R1: reset state and first fetch; R3: fill stops at DEPTH
      settle();
      check(!dec_valid, "R1 empty after reset", dec_valid, 0);
      check(mem_req && mem_addr == 16'h2080 && !du_done, "R1 first fetch address",
            mem_addr, 16'h2080);
      next();
      for (int i = 1; i < 14; i++) begin
         settle();
         if (i >= 4) check(!mem_req, "R3 no fetch while full", mem_req, 0);
         next();
      end
      check(fetch_acks == 4, "R3 fetch count to full", fetch_acks, 4);
      settle();
      check(dec_valid && dec_addr == 16'h2080, "R1 head address", dec_addr, 16'h2080);

      // R3: accept one byte, fetch resumes in the following cycle
      dec_accept = 1'b1;
      next();
      dec_accept = 1'b0;
      settle();
      check(mem_req && mem_addr == 16'h2084 && !du_done, "R3 resume after accept",
            mem_addr, 16'h2084);
      next();
      settle();
      check(!mem_req, "R3 full again", mem_req, 0);
      next();

      // R7/R8: redirect penalty with a zero-wait memory
      redir_valid  = 1'b1;
      redir_target = 16'h4000;
      settle();
      next();
      redir_valid = 1'b0;
      for (int i = 1; i <= 2; i++) begin
         settle();
         check(!mem_req && !dec_valid, "R8 hold after redirect", {mem_req, dec_valid}, 0);
         next();
      end
      settle();
      check(mem_req && mem_addr == 16'h4000 && !dec_valid, "R8 first target fetch",
            mem_addr, 16'h4000);
      next();
      settle();
      check(dec_valid && dec_addr == 16'h4000 && dec_byte == mem_byte(16'h4000),
            "R7 target byte after penalty", dec_addr, 16'h4000);
      next();
      repeat (6) begin settle(); next(); end

      // R4: data request loses to fetches until the queue is full
      redir_valid  = 1'b1;
      redir_target = 16'h5100;
      settle();
      next();
      redir_valid = 1'b0;
      settle(); next();
      settle(); next();
      du_req  = 1'b1;
      du_we   = 1'b0;
      du_addr = 16'h0030;
      for (int i = 0; i < 4; i++) begin
         settle();
         check(!du_done && mem_addr == 16'h5100 + 16'(i), "R4 fetch wins port",
               {du_done, mem_addr}, {1'b0, 16'h5100 + 16'(i)});
         next();
      end
      settle();
      check(du_done, "R4 data granted when full", du_done, 1);
      next();
      du_req = 1'b0;

      // R9: fetch stuck on the port across a redirect is discarded
      stall      = 1'b1;
      dec_accept = 1'b1;
      settle();
      next();
      dec_accept   = 1'b0;
      redir_valid  = 1'b1;
      redir_target = 16'h6200;
      settle();
      check(mem_req && mem_addr == 16'h5104, "R9 fetch pending at redirect",
            mem_addr, 16'h5104);
      next();
      redir_valid = 1'b0;
      settle();
      check(mem_req && mem_addr == 16'h5104 && !dec_valid, "R9 stale fetch held",
            mem_addr, 16'h5104);
      next();
      stall = 1'b0;
      for (int i = 0; i < 12; i++) begin
         settle();
         if (dec_valid) break;
         next();
      end
      check(dec_valid && dec_addr == 16'h6200 && dec_byte == mem_byte(16'h6200),
            "R9 first byte after stale drop", {dec_addr, dec_byte},
            {16'h6200, mem_byte(16'h6200)});
      next();
      repeat (6) begin settle(); next(); end

      // R5: write while the queue is full
      du_req   = 1'b1;
      du_we    = 1'b1;
      du_addr  = 16'h0102;
      du_wdata = 8'h3C;
      settle();
      check(du_done && mem_we && mem_addr == 16'h0102 && mem_wdata == 8'h3C,
            "R5 write on port", {du_done, mem_we, mem_addr, mem_wdata},
            {2'b11, 16'h0102, 8'h3C});
      next();
      du_req = 1'b0;
      du_we  = 1'b0;

      // mixed random traffic: R2, R5, R6 checked by the monitor
      for (int c = 0; c < 4000; c++) begin
         bit done_seen;
         stall       = ($urandom % 100) < 30;
         dec_accept  = ($urandom % 100) < 60;
         redir_valid = ($urandom % 100) < 3;
         redir_target = 16'($urandom);
         if (!du_req && ($urandom % 100) < 15) begin
            du_req   = 1'b1;
            du_we    = $urandom % 2;
            du_addr  = 16'($urandom);
            du_wdata = 8'($urandom);
         end
         settle();
         done_seen = du_done;
         next();
         if (done_seen) du_req = 1'b0;
      end

      summary();
      $finish;
   end
endmodule